// File: doc/BRIEF.md
# Keyboard Scan Code to Text Cursor Controller

This block sits between a PS/2 keyboard receiver and a character-cell text buffer. It takes set-2 scan code bytes, one per `code_valid` strobe, and turns them into single-cycle character writes aimed at an 80-column by 30-row grid. It also keeps a cursor that the display can draw.

Prefix bytes are absorbed. A release prefix stops the following key from typing, although it still lowers the shift flag. An extended prefix marks the following key as a separate key, even when its code matches a normal key. The block holds shift and caps-lock state and picks the lower or upper character from it. Printable keys write at the cursor and step it forward. Enter, backspace and the right arrow only move the cursor.

Top module: `kbd_text_ctrl`

## Requirements
- R1: After reset the cursor is at row 0, column 0, `wr_en` is low, and shift and caps lock are both off.
- R2: A make code for a letter (set-2: a=1C b=32 c=21 d=23 e=24 f=2B g=34 h=33 i=43 j=3B k=42 l=4B m=3A n=31 o=44 p=4D q=15 r=2D s=1B t=2C u=3C v=2A w=1D x=22 y=35 z=1A) writes the letter's ASCII code at the cursor cell. The letter is lower case when neither shift nor caps lock is on.
- R3: Make code 12 turns shift on and the pair F0 12 turns it off. With shift on, letters are upper case and the digit keys (1=16 2=1E 3=26 4=25 5=2E 6=36 7=3D 8=3E 9=46 0=45) give `! @ # $ % ^ & * ( )` in place of the digits.
- R4: Each make code 58 toggles caps lock, and F0 58 leaves it unchanged. Caps lock turns letters upper case, whether or not shift is on. It does not affect the digit keys.
- R5: A byte that follows F0 never writes and never moves the cursor. F0 and E0 themselves never write and never move the cursor.
- R6: E0 74 moves the cursor forward one cell without writing. Any other code that follows E0 does nothing. This includes 75 and the letter codes. The single byte 74 also does nothing.
- R7: A make code that repeats with no release between its copies writes one character for each copy.
- R8: Stepping forward from column 79 goes to column 0 of the next row. Stepping forward from row 29 in that way goes to row 0.
- R9: Enter (5A) sets the column to 0 and moves down one row, wrapping from row 29 to row 0. It writes nothing.
- R10: Backspace (66) moves the column back by one without writing. At column 0 it leaves the cursor unchanged.
- R11: Space (29) writes ASCII 20 at the cursor and then moves the cursor forward.
- R12: A write appears on `wr_en` for exactly the one cycle after the clock edge that samples the byte. It carries the cursor position held before that byte. In the same cycle, `cur_row` and `cur_col` show the updated position. When `code_valid` is low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_valid | input | 1 | Marks `code_byte` valid for this cycle |
| code_byte | input | 8 | Received scan code byte |
| wr_en | output | 1 | One-cycle character write strobe |
| wr_row | output | 5 | Row of the cell being written |
| wr_col | output | 7 | Column of the cell being written |
| wr_char | output | 7 | ASCII code to write |
| cur_row | output | 5 | Cursor row |
| cur_col | output | 7 | Cursor column |

## Verification
Three things can fall in the same cycle: a character write, a column wrap and a row wrap. This happens when a printable key or space lands on the last cell, row 29 column 79. The write must carry that last cell while the cursor moves to row 0, column 0. To provoke it, the bench types well over a full screen of characters. It compares the write address and the new cursor against positions it counts on its own. A second collision is a modifier change followed at once by a key that depends on it. The bench sends F0 12 or 58 immediately before letters and checks the case that results.

// File: rtl/kbd_text_pkg.sv
package kbd_text_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_PRINT,
        K_ENTER,
        K_BKSP,
        K_RIGHT,
        K_SHIFT,
        K_CAPS
    } key_kind_e;

    // one completed key event after prefix stripping
    typedef struct packed {
        logic       valid;
        logic       brk;
        logic       ext;
        logic [7:0] code;
    } key_evt_t;

    typedef struct packed {
        key_kind_e  kind;
        logic [6:0] ascii;
    } key_act_t;

    localparam logic [7:0] PFX_EXT   = 8'hE0;
    localparam logic [7:0] PFX_BREAK = 8'hF0;
    localparam logic [7:0] SC_SHIFT  = 8'h12;
    localparam logic [7:0] SC_CAPS   = 8'h58;
    localparam logic [7:0] SC_ENTER  = 8'h5A;
    localparam logic [7:0] SC_BKSP   = 8'h66;
    localparam logic [7:0] SC_SPACE  = 8'h29;
    localparam logic [7:0] SC_RIGHT  = 8'h74;

    // lower-case letter for a set-2 code, 0 when not a letter
    function automatic logic [6:0] set2_letter(input logic [7:0] c);
        logic [6:0] r;
        case (c)
            8'h1C: r = 7'h61; 8'h32: r = 7'h62; 8'h21: r = 7'h63;
            8'h23: r = 7'h64; 8'h24: r = 7'h65; 8'h2B: r = 7'h66;
            8'h34: r = 7'h67; 8'h33: r = 7'h68; 8'h43: r = 7'h69;
            8'h3B: r = 7'h6A; 8'h42: r = 7'h6B; 8'h4B: r = 7'h6C;
            8'h3A: r = 7'h6D; 8'h31: r = 7'h6E; 8'h44: r = 7'h6F;
            8'h4D: r = 7'h70; 8'h15: r = 7'h71; 8'h2D: r = 7'h72;
            8'h1B: r = 7'h73; 8'h2C: r = 7'h74; 8'h3C: r = 7'h75;
            8'h2A: r = 7'h76; 8'h1D: r = 7'h77; 8'h22: r = 7'h78;
            8'h35: r = 7'h79; 8'h1A: r = 7'h7A;
            default: r = 7'h00;
        endcase
        return r;
    endfunction

    // {hit, unshifted, shifted} for the digit row
    function automatic logic [14:0] set2_digit(input logic [7:0] c);
        logic [14:0] r;
        case (c)
            8'h16: r = {1'b1, 7'h31, 7'h21};
            8'h1E: r = {1'b1, 7'h32, 7'h40};
            8'h26: r = {1'b1, 7'h33, 7'h23};
            8'h25: r = {1'b1, 7'h34, 7'h24};
            8'h2E: r = {1'b1, 7'h35, 7'h25};
            8'h36: r = {1'b1, 7'h36, 7'h5E};
            8'h3D: r = {1'b1, 7'h37, 7'h26};
            8'h3E: r = {1'b1, 7'h38, 7'h2A};
            8'h46: r = {1'b1, 7'h39, 7'h28};
            8'h45: r = {1'b1, 7'h30, 7'h29};
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/kbd_prefix_filter.sv
module kbd_prefix_filter
    import kbd_text_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output key_evt_t   evt
);

    typedef struct packed {
        logic brk;
        logic ext;
    } pfx_st_t;

    pfx_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        evt.valid = 1'b0;
        evt.brk   = st_q.brk;
        evt.ext   = st_q.ext;
        evt.code  = in_byte;
        if (in_valid) begin
            if (in_byte == PFX_EXT) begin
                st_d.ext = 1'b1;
            end else if (in_byte == PFX_BREAK) begin
                st_d.brk = 1'b1;
            end else begin
                evt.valid = 1'b1;
                st_d      = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/kbd_keymap.sv
module kbd_keymap
    import kbd_text_pkg::*;
(
    input  key_evt_t evt,
    input  logic     shift,
    input  logic     caps,
    output key_act_t act
);

    logic [6:0]  letter;
    logic [14:0] digit;

    always_comb begin
        letter    = set2_letter(evt.code);
        digit     = set2_digit(evt.code);
        act.kind  = K_NONE;
        act.ascii = 7'h00;
        if (evt.ext) begin
            if (evt.code == SC_RIGHT) act.kind = K_RIGHT;
        end else if (evt.code == SC_SHIFT) begin
            act.kind = K_SHIFT;
        end else if (evt.code == SC_CAPS) begin
            act.kind = K_CAPS;
        end else if (evt.code == SC_ENTER) begin
            act.kind = K_ENTER;
        end else if (evt.code == SC_BKSP) begin
            act.kind = K_BKSP;
        end else if (evt.code == SC_SPACE) begin
            act.kind  = K_PRINT;
            act.ascii = 7'h20;
        end else if (letter != 7'h00) begin
            act.kind  = K_PRINT;
            act.ascii = (shift || caps) ? (letter - 7'h20) : letter;
        end else if (digit[14]) begin
            act.kind  = K_PRINT;
            act.ascii = shift ? digit[6:0] : digit[13:7];
        end
    end

endmodule

// File: rtl/kbd_modifiers.sv
module kbd_modifiers
    import kbd_text_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fire,
    input  logic      brk,
    input  key_kind_e kind,
    output logic      shift,
    output logic      caps
);

    typedef struct packed {
        logic shift;
        logic caps;
    } mod_st_t;

    mod_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            if (kind == K_SHIFT) st_d.shift = !brk;
            if (kind == K_CAPS && !brk) st_d.caps = !st_q.caps;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shift = st_q.shift;
    assign caps  = st_q.caps;

endmodule

// File: rtl/kbd_cursor.sv
module kbd_cursor
    import kbd_text_pkg::*;
#(
    parameter int COLS = 80,
    parameter int ROWS = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  key_act_t        act,
    output logic            wr_en,
    output logic [$clog2(ROWS)-1:0] wr_row,
    output logic [$clog2(COLS)-1:0] wr_col,
    output logic [6:0]      wr_char,
    output logic [$clog2(ROWS)-1:0] cur_row,
    output logic [$clog2(COLS)-1:0] cur_col
);

    localparam int CW = $clog2(COLS);
    localparam int RW = $clog2(ROWS);
    localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic          wr;
        logic [RW-1:0] wrow;
        logic [CW-1:0] wcol;
        logic [6:0]    wch;
    } cur_st_t;

    cur_st_t st_d, st_q;
    logic [RW-1:0] row_next;

    always_comb begin
        st_d     = st_q;
        st_d.wr  = 1'b0;
        row_next = (st_q.row == ROW_LAST) ? '0 : st_q.row + RW'(1);
        if (fire) begin
            case (act.kind)
                K_PRINT, K_RIGHT: begin
                    if (act.kind == K_PRINT) begin
                        st_d.wr   = 1'b1;
                        st_d.wrow = st_q.row;
                        st_d.wcol = st_q.col;
                        st_d.wch  = act.ascii;
                    end
                    if (st_q.col == COL_LAST) begin
                        st_d.col = '0;
                        st_d.row = row_next;
                    end else begin
                        st_d.col = st_q.col + CW'(1);
                    end
                end
                K_ENTER: begin
                    st_d.col = '0;
                    st_d.row = row_next;
                end
                K_BKSP: begin
                    if (st_q.col != '0) st_d.col = st_q.col - CW'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = st_q.wr;
    assign wr_row  = st_q.wrow;
    assign wr_col  = st_q.wcol;
    assign wr_char = st_q.wch;
    assign cur_row = st_q.row;
    assign cur_col = st_q.col;

endmodule

// File: rtl/kbd_text_ctrl.sv
module kbd_text_ctrl
    import kbd_text_pkg::*;
#(
    parameter int COLS = 80,
    parameter int ROWS = 30
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    code_valid,
    input  logic [7:0]              code_byte,
    output logic                    wr_en,
    output logic [$clog2(ROWS)-1:0] wr_row,
    output logic [$clog2(COLS)-1:0] wr_col,
    output logic [6:0]              wr_char,
    output logic [$clog2(ROWS)-1:0] cur_row,
    output logic [$clog2(COLS)-1:0] cur_col
);

    key_evt_t evt;
    key_act_t act;
    logic     shift, caps;
    logic     make_fire;

    kbd_prefix_filter u_pfx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (code_valid),
        .in_byte  (code_byte),
        .evt      (evt)
    );

    kbd_keymap u_map (
        .evt   (evt),
        .shift (shift),
        .caps  (caps),
        .act   (act)
    );

    kbd_modifiers u_mod (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (evt.valid),
        .brk   (evt.brk),
        .kind  (act.kind),
        .shift (shift),
        .caps  (caps)
    );

    assign make_fire = evt.valid && !evt.brk;

    kbd_cursor #(.COLS(COLS), .ROWS(ROWS)) u_cur (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (make_fire),
        .act     (act),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_col  (wr_col),
        .wr_char (wr_char),
        .cur_row (cur_row),
        .cur_col (cur_col)
    );

endmodule

// File: rtl/kbd_text_ctrl_chk.sv
module kbd_text_ctrl_chk #(
    parameter int COLS = 80,
    parameter int ROWS = 30
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    code_valid,
    input logic [7:0]              code_byte,
    input logic                    wr_en,
    input logic [$clog2(ROWS)-1:0] wr_row,
    input logic [$clog2(COLS)-1:0] wr_col,
    input logic [6:0]              wr_char,
    input logic [$clog2(ROWS)-1:0] cur_row,
    input logic [$clog2(COLS)-1:0] cur_col
);

    a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |=> !wr_en);

    a_r12_idle_cursor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |=> ($stable(cur_row) && $stable(cur_col)));

    a_r12_write_at_old_cursor: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_row == $past(cur_row) && wr_col == $past(cur_col)));

    a_r5_prefix_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && (code_byte == 8'hF0 || code_byte == 8'hE0))
        |=> (!wr_en && $stable(cur_row) && $stable(cur_col)));

    a_r8_cursor_in_grid: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cur_col) < COLS) && (int'(cur_row) < ROWS));

    a_r2_printable_char: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_char >= 7'h20 && wr_char < 7'h7F));

    a_r10_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_col) |-> (cur_col == $past(cur_col) + 1'b1 ||
                               cur_col + 1'b1 == $past(cur_col) ||
                               cur_col == '0));

endmodule

bind kbd_text_ctrl kbd_text_ctrl_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code_byte  (code_byte),
    .wr_en      (wr_en),
    .wr_row     (wr_row),
    .wr_col     (wr_col),
    .wr_char    (wr_char),
    .cur_row    (cur_row),
    .cur_col    (cur_col)
);

// File: tb/sim_kbd_text_ctrl.sv
module sim_kbd_text_ctrl;

    localparam int COLS = 80;
    localparam int ROWS = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       code_valid = 1'b0;
    logic [7:0] code_byte = 8'h00;
    logic       wr_en;
    logic [4:0] wr_row;
    logic [6:0] wr_col;
    logic [6:0] wr_char;
    logic [4:0] cur_row;
    logic [6:0] cur_col;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state
    bit m_brk, m_ext, m_shift, m_caps;
    int m_row, m_col;

    string     lt_chars = "abcdefghijklmnopqrstuvwxyz";
    logic [7:0] lt_codes [26] = '{8'h1C,8'h32,8'h21,8'h23,8'h24,8'h2B,8'h34,8'h33,8'h43,
                                  8'h3B,8'h42,8'h4B,8'h3A,8'h31,8'h44,8'h4D,8'h15,8'h2D,
                                  8'h1B,8'h2C,8'h3C,8'h2A,8'h1D,8'h22,8'h35,8'h1A};
    string     dg_low = "1234567890";
    string     dg_up  = "!@#$%^&*()";
    logic [7:0] dg_codes [10] = '{8'h16,8'h1E,8'h26,8'h25,8'h2E,8'h36,8'h3D,8'h3E,8'h46,8'h45};

    always #10 clk = ~clk;

    kbd_text_ctrl #(.COLS(COLS), .ROWS(ROWS)) u0 (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_byte(code_byte),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_char(wr_char),
        .cur_row(cur_row), .cur_col(cur_col)
    );

    function automatic void step_fwd();
        if (m_col == COLS - 1) begin
            m_col = 0;
            m_row = (m_row + 1) % ROWS;
        end else begin
            m_col = m_col + 1;
        end
    endfunction

    task automatic check(input string tag, input bit ok, input string got, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %s expected %s", tag, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        bit e_wr = 0;
        int e_r = m_row, e_c = m_col;
        int e_ch = 0;
        bit hit = 0;
        if (b == 8'hE0) m_ext = 1;
        else if (b == 8'hF0) m_brk = 1;
        else begin
            if (m_ext) begin
                if (!m_brk && b == 8'h74) step_fwd();
            end else if (m_brk) begin
                if (b == 8'h12) m_shift = 0;
            end else if (b == 8'h12) m_shift = 1;
            else if (b == 8'h58) m_caps = !m_caps;
            else if (b == 8'h5A) begin m_col = 0; m_row = (m_row + 1) % ROWS; end
            else if (b == 8'h66) begin if (m_col > 0) m_col--; end
            else if (b == 8'h29) begin e_wr = 1; e_ch = 32; step_fwd(); end
            else begin
                for (int i = 0; i < 26; i++)
                    if (lt_codes[i] == b) begin
                        hit = 1;
                        e_ch = (m_shift || m_caps) ? int'(lt_chars[i]) - 32 : int'(lt_chars[i]);
                    end
                for (int i = 0; i < 10; i++)
                    if (dg_codes[i] == b) begin
                        hit = 1;
                        e_ch = m_shift ? int'(dg_up[i]) : int'(dg_low[i]);
                    end
                if (hit) begin e_wr = 1; step_fwd(); end
            end
            m_brk = 0;
            m_ext = 0;
        end
        @(negedge clk);
        code_valid = 1'b1;
        code_byte  = b;
        @(negedge clk);
        code_valid = 1'b0;
        check(tag,
              wr_en == e_wr && (!e_wr || (int'(wr_row) == e_r && int'(wr_col) == e_c &&
                                          int'(wr_char) == e_ch)) &&
              int'(cur_row) == m_row && int'(cur_col) == m_col,
              $sformatf("byte %02h wr=%0d @%0d,%0d ch=%02h cur=%0d,%0d", b, wr_en, wr_row,
                        wr_col, wr_char, cur_row, cur_col),
              $sformatf("wr=%0d @%0d,%0d ch=%02h cur=%0d,%0d", e_wr, e_r, e_c, e_ch,
                        m_row, m_col));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset", wr_en == 0 && cur_row == 0 && cur_col == 0,
              $sformatf("wr=%0d cur=%0d,%0d", wr_en, cur_row, cur_col), "wr=0 cur=0,0");

        // R2 lower-case letters
        for (int i = 0; i < 26; i++) send(lt_codes[i], "R2 letter lower");
        // R3 digits unshifted, then shifted, then release
        for (int i = 0; i < 10; i++) send(dg_codes[i], "R3 digit plain");
        send(8'h12, "R3 shift make");
        for (int i = 0; i < 26; i++) send(lt_codes[i], "R3 letter shifted");
        for (int i = 0; i < 10; i++) send(dg_codes[i], "R3 digit shifted");
        send(8'hF0, "R5 break prefix"); send(8'h12, "R3 shift release");
        send(8'h1C, "R3 after release");
        // R4 caps lock
        send(8'h58, "R4 caps on");
        for (int i = 0; i < 26; i++) send(lt_codes[i], "R4 letter caps");
        for (int i = 0; i < 10; i++) send(dg_codes[i], "R4 digit caps");
        send(8'h12, "R4 shift with caps");
        send(8'h24, "R4 caps+shift letter");
        send(8'hF0, "R4 break"); send(8'h12, "R4 shift off");
        send(8'hF0, "R4 break"); send(8'h58, "R4 caps break no toggle");
        send(8'h32, "R4 still caps");
        send(8'h58, "R4 caps off");
        send(8'h32, "R4 caps cleared");
        // R7 repeats
        for (int i = 0; i < 5; i++) send(8'h2B, "R7 repeat");
        // R5 break of printable
        send(8'hF0, "R5 break"); send(8'h2B, "R5 break no write");
        // R9, R10, R11
        send(8'h5A, "R9 enter");
        send(8'h66, "R10 backspace at col 0");
        send(8'h29, "R11 space");
        send(8'h29, "R11 space");
        send(8'h66, "R10 backspace");
        // R6 extended handling
        send(8'hE0, "R6 ext prefix"); send(8'h74, "R6 right arrow");
        send(8'h74, "R6 bare 74");
        send(8'hE0, "R6 ext prefix"); send(8'h75, "R6 up arrow");
        send(8'hE0, "R6 ext prefix"); send(8'h1C, "R6 ext letter");
        send(8'hE0, "R6 ext"); send(8'hF0, "R6 ext break"); send(8'h74, "R6 right release");
        // R12 idle cycles
        repeat (5) @(negedge clk);
        check("R12 idle", wr_en == 0 && int'(cur_row) == m_row && int'(cur_col) == m_col,
              $sformatf("wr=%0d cur=%0d,%0d", wr_en, cur_row, cur_col),
              $sformatf("wr=0 cur=%0d,%0d", m_row, m_col));
        // R8 fill beyond a full screen: column and row wraps with writes
        for (int i = 0; i < COLS * ROWS + 100; i++)
            send(lt_codes[i % 26], "R8 fill wrap");
        for (int i = 0; i < COLS * 2 + 7; i++) begin
            send(8'hE0, "R8 ext"); send(8'h74, "R8 right wrap");
        end
        for (int i = 0; i < ROWS + 3; i++) send(8'h5A, "R9 enter wrap");
        // near-exhaustive byte sweeps
        for (int b = 0; b < 256; b++) send(8'(b), "R12 single sweep");
        for (int b = 0; b < 256; b++) begin
            send(8'hF0, "R5 sweep prefix"); send(8'(b), "R5 break sweep");
        end
        for (int b = 0; b < 256; b++) begin
            send(8'hE0, "R6 sweep prefix"); send(8'(b), "R6 ext sweep");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule